// File: doc/BRIEF.md
# Bounce Direction Latch and Reversal Counter

This block sits beside a column integrator that ramps between two voltage limits. Two threshold comparators tell it when the ramp has touched the upper limit or the lower limit. The block keeps a direction flag that says which way the integrator must ramp next: low means ramp up, high means ramp down. It counts every reversal of that flag during one integration window.

A global active-high window reset defines the integration period. While it is high, the flag and the count are held at zero. While it is low, each flip of the flag in either direction adds one to a saturating counter of parameter width. When the count reaches its all-ones value, a saturation flag is raised and all later reversals are ignored. Overflow is therefore recorded rather than wrapped.

The saturation flag survives the window reset, so a readout stage can still capture it. It is cleared as the next window opens. Both comparator inputs are assumed to be synchronous to the system clock already.

Top module: `bounce_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count`, `max_flag` and `dir_down` are all zero after that edge.
- R2: With `win_rst` low, `hit_hi` high alone sets `dir_down` to 1 at the next edge, and `hit_lo` high alone clears it to 0 at the next edge.
- R3: With `win_rst` low, when `hit_hi` and `hit_lo` are both high in the same cycle, `dir_down` keeps its value.
- R4: During a window, each change of `dir_down` (0 to 1 or 1 to 0) raises `count` by exactly one, one clock edge after `dir_down` changes. Otherwise `count` does not move.
- R5: While `win_rst` is high, `dir_down` and `count` are zero after each edge and the comparator inputs have no effect. Flips of the flag seen across the window reset are never counted.
- R6: `max_flag` rises at the same edge at which `count` reaches 2^CNT_W−1. From then on, `count` stays at that value and further flips are not counted.
- R7: `max_flag` keeps its value through every edge at which `win_rst` is high. It is cleared at the first edge at which `win_rst` is sampled low after having been high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_rst | input | 1 | Active-high window reset; low marks the integration period |
| hit_hi | input | 1 | Comparator: integrator reached the upper limit |
| hit_lo | input | 1 | Comparator: integrator reached the lower limit |
| count | output | CNT_W | Number of direction reversals in the current window |
| max_flag | output | 1 | Counter saturated in this window (held until the next window opens) |
| dir_down | output | 1 | Direction flag: 0 ramp up, 1 ramp down |

## Verification
A corrupted direction flag shows on `dir_down` one edge after the comparator stimulus. It shows on `count` one edge later, because the edge detector then sees a false or a missing flip. A stale copy of the flag left over from the window reset would show as a count of one in the first window cycle. A wrong saturation compare shows as a count that wraps to zero, or as `max_flag` rising one edge away from the all-ones value. A lost window-start pulse shows as `max_flag` still high at the start of the next window. The bench compares all three outputs against its own cycle model on every clock. Any of these faults therefore appears within two cycles of the stimulus that provokes it.

// File: rtl/bt_pkg.sv
// Package: shared types and helpers for the bounce tracker.
package bt_pkg;

    // Ramp direction requested from the integrator.
    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } ramp_dir_e;

    // Next direction of the set/reset latch; both inputs high keeps the state.
    function automatic ramp_dir_e next_ramp(ramp_dir_e cur, logic up_hit, logic low_hit);
        ramp_dir_e nxt;
        nxt = cur;
        if (up_hit && !low_hit) begin
            nxt = DIR_FALL;
        end else if (low_hit && !up_hit) begin
            nxt = DIR_RISE;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bt_window_ctl.sv
// Module: bt_window_ctl
// Tracks the window reset and produces a one-cycle pulse in the first
// integration cycle after the window reset has been high.
// Assumes win_rst is synchronous to clk.
module bt_window_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic win_rst,
    output logic win_start
);

    logic win_q;

    // Registered copy of the window reset for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else begin
            win_q <= win_rst;
        end
    end

    // Window opens when the reset was high last cycle and is low now.
    assign win_start = win_q && !win_rst;

    // R7: the start pulse only lasts one cycle.
    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> !win_start);

endmodule

// File: rtl/bt_dir_latch.sv
// Module: bt_dir_latch
// Set/reset direction latch driven by the two limit comparators, with a
// registered copy used to detect every flip of the flag.
// Assumes hit_hi/hit_lo are already synchronous to clk.
module bt_dir_latch
    import bt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      win_rst,
    input  logic      hit_hi,
    input  logic      hit_lo,
    output ramp_dir_e dir,
    output logic      flip
);

    ramp_dir_e dir_q;

    // Direction latch: cleared in window reset, otherwise set/reset by comparators.
    always_ff @(posedge clk) begin
        if (!rst_n || win_rst) begin
            dir <= DIR_RISE;
        end else begin
            dir <= next_ramp(dir, hit_hi, hit_lo);
        end
    end

    // Delayed copy, cleared together with the flag so no stale flip survives.
    always_ff @(posedge clk) begin
        if (!rst_n || win_rst) begin
            dir_q <= DIR_RISE;
        end else begin
            dir_q <= dir;
        end
    end

    // A flip is any difference between the flag and its delayed copy.
    assign flip = (dir != dir_q);

    assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_hi && !hit_lo && !win_rst) |=> (dir == DIR_FALL));

    assert_dir_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lo && !hit_hi && !win_rst) |=> (dir == DIR_RISE));

    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_hi && hit_lo && !win_rst) |=> $stable(dir));

    assert_win_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_rst |=> (dir == DIR_RISE && !flip));

endmodule

// File: rtl/bt_sat_counter.sv
// Module: bt_sat_counter
// Saturating up-counter of CW bits with a sticky full flag. The count clears
// on clr; the full flag survives clr and is cleared only by restart.
// Assumes clr and restart are never high together.
module bt_sat_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          restart,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          full
);

    localparam logic [CW-1:0] TOP    = {CW{1'b1}};
    localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] TOP_M1 = TOP - ONE;

    logic take;

    // A step is taken only inside the window and before saturation.
    assign take = step && !clr && !full;

    // Count register: cleared by reset or clr, advanced by accepted steps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt + ONE;
        end
    end

    // Sticky saturation flag: set on reaching TOP, cleared when the window opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (restart) begin
            full <= 1'b0;
        end else if (take && cnt == TOP_M1) begin
            full <= 1'b1;
        end
    end

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE));

    assert_full_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> (cnt == TOP));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> $stable(cnt));

    assert_full_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (full == $past(full)));

    initial begin
        assert_cw_ok: assert (CW >= 1);
    end

endmodule

// File: rtl/bounce_tracker.sv
// Module: bounce_tracker
// Tracks the ramp direction of a column integrator and counts its reversals
// in one integration window, saturating with a sticky flag.
// Assumes comparator inputs and win_rst are synchronous to clk.
module bounce_tracker
    import bt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_rst,
    input  logic             hit_hi,
    input  logic             hit_lo,
    output logic [CNT_W-1:0] count,
    output logic             max_flag,
    output logic             dir_down
);

    ramp_dir_e dir;
    logic      flip;
    logic      win_start;

    bt_window_ctl u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_rst   (win_rst),
        .win_start (win_start)
    );

    bt_dir_latch u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_rst (win_rst),
        .hit_hi  (hit_hi),
        .hit_lo  (hit_lo),
        .dir     (dir),
        .flip    (flip)
    );

    bt_sat_counter #(.CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_rst),
        .restart (win_start),
        .step    (flip),
        .cnt     (count),
        .full    (max_flag)
    );

    // Direction flag brought out as a plain bit.
    assign dir_down = (dir == DIR_FALL);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !max_flag && !dir_down));

    assert_win_count_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_rst |=> (count == '0));

    assert_flip_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_rst && !max_flag && $past(!win_rst) && (dir_down != $past(dir_down)))
        |=> (count != $past(count)));

endmodule

// File: tb/bounce_tracker_tb_top.sv
module bounce_tracker_tb_top;

    localparam int W   = 8;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         win_rst = 1'b1;
    logic         hit_hi = 1'b0;
    logic         hit_lo = 1'b0;
    logic [W-1:0] count;
    logic         max_flag;
    logic         dir_down;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 1'b0;

    // Reference model state
    bit m_dir, m_prev, m_max, m_winq;
    int m_cnt;

    always #4 clk = ~clk;

    bounce_tracker #(.CNT_W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_rst  (win_rst),
        .hit_hi   (hit_hi),
        .hit_lo   (hit_lo),
        .count    (count),
        .max_flag (max_flag),
        .dir_down (dir_down)
    );

    // Next flag value from the requirements (R2, R3, R5).
    function automatic bit exp_dir(bit cur, bit hi, bit lo, bit win);
        if (win) return 1'b0;
        if (hi && !lo) return 1'b1;
        if (lo && !hi) return 1'b0;
        return cur;
    endfunction

    // Cycle model of the specified behaviour.
    always @(posedge clk) begin
        bit flipped;
        flipped = (m_dir != m_prev);
        if (!rst_n) begin
            m_dir = 0; m_prev = 0; m_cnt = 0; m_max = 0; m_winq = 0;
        end else begin
            if (!win_rst && m_winq) begin
                m_max = 0;
            end else if (!win_rst && flipped && !m_max && m_cnt + 1 == TOP) begin
                m_max = 1;
            end
            if (win_rst) m_cnt = 0;
            else if (flipped && !m_max_before(flipped)) m_cnt = m_cnt + 1;
            m_prev = win_rst ? 1'b0 : m_dir;
            m_dir  = exp_dir(m_dir, hit_hi, hit_lo, win_rst);
            m_winq = win_rst;
        end
    end

    // Saturation state before this edge: count already at top means blocked.
    function automatic bit m_max_before(bit f);
        return (m_cnt >= TOP);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model away from the active edge.
    task automatic step(bit hi, bit lo, bit win);
        @(negedge clk);
        hit_hi  = hi;
        hit_lo  = lo;
        win_rst = win;
        @(negedge clk);
        check(phase, count, m_cnt, "count");
        check(phase, max_flag, m_max, "max_flag");
        check(phase, dir_down, m_dir, "dir_down");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with noisy inputs
        phase = "R1";
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'($urandom), 1'($urandom), 1'($urandom));
        check("R1", count, 0, "count after reset");
        check("R1", max_flag, 0, "max_flag after reset");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 1);

        // R2 and R4: directed set/clear and counting
        phase = "R2";
        step(0, 0, 0);
        step(1, 0, 0);
        check("R2", dir_down, 1, "dir after hit_hi");
        step(0, 0, 0);
        check("R4", count, 1, "count after rising flip");
        step(0, 1, 0);
        check("R2", dir_down, 0, "dir after hit_lo");
        step(0, 0, 0);
        check("R4", count, 2, "count after falling flip");

        // R3: both comparators together hold the flag
        phase = "R3";
        step(1, 1, 0);
        check("R3", dir_down, 0, "dir hold low");
        step(1, 0, 0);
        step(1, 1, 0);
        check("R3", dir_down, 1, "dir hold high");
        step(0, 0, 0);
        check("R4", count, 3, "count after hold");

        // R5: window reset ignores comparators, clears count and flag
        phase = "R5";
        step(1, 0, 1);
        check("R5", dir_down, 0, "dir in window reset");
        check("R5", count, 0, "count in window reset");
        step(0, 0, 0);
        step(0, 0, 0);
        check("R5", count, 0, "no stale flip across window reset");

        // Random mix of comparator pulses and window resets
        phase = "R4/R5 random";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r < 30, (r >= 30 && r < 60) || r > 95, r >= 97);
        end

        // R6: saturation by alternating limits
        phase = "R6";
        step(0, 0, 1);
        for (int i = 0; i < 300; i++) step(i % 2 == 0, i % 2 == 1, 0);
        step(0, 0, 0);
        check("R6", count, TOP, "count saturated");
        check("R6", max_flag, 1, "max_flag set");
        step(1, 0, 0); step(0, 1, 0); step(0, 0, 0);
        check("R6", count, TOP, "count frozen after more flips");

        // R7: saturation flag kept through window reset, cleared at window start
        phase = "R7";
        for (int i = 0; i < 4; i++) step(1'($urandom), 1'($urandom), 1);
        check("R7", max_flag, 1, "max_flag kept in window reset");
        check("R5", count, 0, "count cleared in window reset");
        step(0, 0, 0);
        check("R7", max_flag, 0, "max_flag cleared at window start");

        // Random tail with short windows and saturation runs
        phase = "R6/R7 random";
        for (int i = 0; i < 2000; i++) begin
            step(1'($urandom), 1'($urandom), ($urandom_range(0, 299) == 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule